// File: doc/BRIEF.md
# Excess-One Carry Select Adder

This block adds two 32-bit operands and a carry-in, and returns a 32-bit sum and a carry-out. It has no clock and holds no state. The operand bits are divided into equal groups. The lowest group is a plain ripple adder that takes the external carry-in. Each higher group adds its bits once, with the carry-in held at zero.

For each higher group, the result it would give with a carry-in of one comes from a small increment stage. This stage adds one to the concatenation of the group's carry and sum. A 2:1 selector then picks the zero-carry result or the incremented result, for both the sum bits and the carry. The carry arriving from the group below drives that selector. A single second ripple adder per group is therefore replaced by one XOR and one AND per bit.

The group width is a compile-time parameter. The supported widths are 4, 8 and 16, which give eight, four or two groups over the 32-bit word.

Top module: `excess1_csel_adder`

## Requirements
- R1: With the default group width of 8, {cout_o, sum_o} equals the 33-bit value a_i + b_i + cin_i for every input combination.
- R2: With the group width set to 4 or to 16, the outputs equal the same 33-bit value a_i + b_i + cin_i.
- R3: cin_i is added at bit 0: with a_i = 0, b_i = 0 and cin_i = 1, sum_o is 0x00000001 and cout_o is 0.
- R4: With a_i = 0xFFFFFFFF, b_i = 0 and cin_i = 1, sum_o is 0 and cout_o is 1. With a_i = 0xFFFFFFFF, b_i = 1 and cin_i = 0, the result is the same.
- R5: With zero operands and cin_i = 0, sum_o is 0 and cout_o is 0.
- R6: A carry leaving a group reaches the group above. For example, 0x000000FF + 0x00000001 gives 0x00000100, and 0x0000FFFF + 0x00000001 gives 0x00010000, each with cout_o = 0.
- R7: cout_o is the carry chosen for the top group. For example, 0x80000000 + 0x80000000 gives sum 0 and cout_o = 1, and 0x7FFFFFFF + 0x00000001 gives 0x80000000 with cout_o = 0.
- R8: When the carry into a higher group is one, that group's output equals its zero-carry sum and carry, as a (group width + 1)-bit value, plus one. For example, 0x55555555 + 0xAAAAAAAA + 1 gives sum 0 and cout_o = 1, and 0xAAAAAAAA + 0x55555555 + 0 gives 0xFFFFFFFF with cout_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cin_i | input | 1 | Carry-in, added at bit 0 |
| sum_o | output | 32 | Sum bits |
| cout_o | output | 1 | Carry-out of the most significant group |

## Verification
The assertions check the full result, each group's outgoing carry, and each increment stage. They assume that every operand and carry-in bit holds a known 0 or 1 value; while any input is unknown, the checks are skipped. The bench drives all three inputs with defined values from time zero and changes them only away from the sampling point. The bench uses directed carry-chain patterns across the group boundaries and seeded random vectors. It runs these on instances with group widths of 4, 8 and 16.

// File: rtl/excess1_csel_adder.sv
module excess1_csel_adder #(
  parameter int W  = 32,
  parameter int GW = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  localparam int NG = W / GW;

  initial begin
    if ((W % GW) != 0) $error("group width must divide the operand width");
  end

  logic [W-1:0]         zs_all;
  logic [NG-1:0]        zc_all;
  logic [NG*(GW+1)-1:0] inc_all;
  logic [NG-1:0]        gcar;

  logic inputs_known;
  assign inputs_known = !$isunknown({a_i, b_i, cin_i});

  for (genvar k = 0; k < NG; k++) begin : g_grp
    logic [GW-1:0] zs;
    logic          zc;
    logic          rc_in;
    logic [GW:0]   inc;

    if (k == 0) begin : g_base
      assign rc_in = cin_i;
    end else begin : g_upper
      assign rc_in = 1'b0;
    end

    always_comb begin
      logic c;
      c = rc_in;
      for (int i = 0; i < GW; i++) begin
        zs[i] = a_i[k*GW+i] ^ b_i[k*GW+i] ^ c;
        c = (a_i[k*GW+i] & b_i[k*GW+i]) | (c & (a_i[k*GW+i] ^ b_i[k*GW+i]));
      end
      zc = c;
    end

    always_comb begin
      logic          run;
      logic [GW:0]   x;
      x   = {zc, zs};
      run = 1'b1;
      for (int i = 0; i <= GW; i++) begin
        inc[i] = x[i] ^ run;
        run    = run & x[i];
      end
    end

    assign zs_all[k*GW +: GW]          = zs;
    assign zc_all[k]                   = zc;
    assign inc_all[k*(GW+1) +: GW+1]   = inc;

    localparam int HI = (k + 1) * GW;
    logic [HI:0] low_ref;
    assign low_ref = {1'b0, a_i[HI-1:0]} + {1'b0, b_i[HI-1:0]} + {{HI{1'b0}}, cin_i};

    always_comb begin
      if (inputs_known) begin
        p_group_carry_r6: assert (gcar[k] == low_ref[HI])
          else $error("group %0d carry mismatch", k);
      end
    end

    if (k > 0) begin : g_inc_chk
      always_comb begin
        if (inputs_known) begin
          p_excess_one_r8: assert (inc == ({zc, zs} + {{GW{1'b0}}, 1'b1}))
            else $error("group %0d increment mismatch", k);
        end
      end
    end
  end

  always_comb begin
    logic c;
    c = zc_all[0];
    sum_o[GW-1:0] = zs_all[GW-1:0];
    gcar[0] = c;
    for (int k = 1; k < NG; k++) begin
      if (c) begin
        sum_o[k*GW +: GW] = inc_all[k*(GW+1) +: GW];
        c = inc_all[k*(GW+1) + GW];
      end else begin
        sum_o[k*GW +: GW] = zs_all[k*GW +: GW];
        c = zc_all[k];
      end
      gcar[k] = c;
    end
  end

  assign cout_o = gcar[NG-1];

  logic [W:0] full_ref;
  assign full_ref = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

  always_comb begin
    if (inputs_known) begin
      p_sum_exact_r1: assert ({cout_o, sum_o} == full_ref)
        else $error("sum mismatch");
      p_cout_top_r7: assert (cout_o == full_ref[W])
        else $error("carry-out mismatch");
    end
  end

endmodule

// File: tb/excess1_csel_adder_bench.sv
module excess1_csel_adder_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        cin = 1'b0;
  logic [31:0] s8, s4, s16;
  logic        c8, c4, c16;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  excess1_csel_adder #(.W(32), .GW(8)) u_excess1_csel_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s8), .cout_o(c8));
  excess1_csel_adder #(.W(32), .GW(4)) u_excess1_csel_adder_g4 (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s4), .cout_o(c4));
  excess1_csel_adder #(.W(32), .GW(16)) u_excess1_csel_adder_g16 (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s16), .cout_o(c16));

  function automatic logic [32:0] ref_add(logic [31:0] x, logic [31:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {32'd0, ci};
  endfunction

  task automatic cmp(string tag, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%b actual=%h expected=%h", tag, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] x, logic [31:0] y, logic ci);
    @(posedge clk);
    a = x; b = y; cin = ci;
    @(negedge clk);
  endtask

  task automatic run_all(string tag, logic [31:0] x, logic [31:0] y, logic ci);
    apply(x, y, ci);
    cmp({tag, " R1 gw8"},  {c8,  s8},  ref_add(x, y, ci));
    cmp({tag, " R2 gw4"},  {c4,  s4},  ref_add(x, y, ci));
    cmp({tag, " R2 gw16"}, {c16, s16}, ref_add(x, y, ci));
  endtask

  task automatic fixed(string tag, logic [31:0] x, logic [31:0] y, logic ci, logic [32:0] exp);
    apply(x, y, ci);
    cmp({tag, " gw8"},  {c8,  s8},  exp);
    cmp({tag, " gw4"},  {c4,  s4},  exp);
    cmp({tag, " gw16"}, {c16, s16}, exp);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    fixed("R5 zero plus zero", 32'h0, 32'h0, 1'b0, 33'h0_0000_0000);
    fixed("R3 carry-in only", 32'h0, 32'h0, 1'b1, 33'h0_0000_0001);
    fixed("R4 ones plus cin", 32'hFFFF_FFFF, 32'h0, 1'b1, 33'h1_0000_0000);
    fixed("R4 ones plus one", 32'hFFFF_FFFF, 32'h1, 1'b0, 33'h1_0000_0000);
    fixed("R6 byte boundary", 32'h0000_00FF, 32'h1, 1'b0, 33'h0_0000_0100);
    fixed("R6 half boundary", 32'h0000_FFFF, 32'h1, 1'b0, 33'h0_0001_0000);
    fixed("R6 nibble boundary", 32'h0000_000F, 32'h1, 1'b0, 33'h0_0000_0010);
    fixed("R7 top carry", 32'h8000_0000, 32'h8000_0000, 1'b0, 33'h1_0000_0000);
    fixed("R7 no top carry", 32'h7FFF_FFFF, 32'h1, 1'b0, 33'h0_8000_0000);
    fixed("R8 alternating chain", 32'h5555_5555, 32'hAAAA_AAAA, 1'b1, 33'h1_0000_0000);
    fixed("R8 alternating no cin", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 33'h0_FFFF_FFFF);
    fixed("R8 group chain", 32'h00FF_00FF, 32'h0000_FF01, 1'b0, 33'h0_0100_0000);
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] x, y;
      x = $urandom();
      y = $urandom();
      if (n % 4 == 1) y = ~x;
      run_all("R1 random", x, y, 1'($urandom()));
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule